// File: doc/BRIEF.md
# Write-only two-wire display link receiver

This block is the slave side of a two-wire serial link that feeds a display controller. It only accepts writes. SCL and SDA are brought into the system clock domain through flop synchronisers, and every bus event is found there: a start (SDA falls while SCL is high), a stop (SDA rises while SCL is high), and the rising and falling edges of SCL. Bits are shifted in MSB first on SCL rising edges. The block answers each accepted byte with an open-drain acknowledge, pulling SDA low for the ninth clock.

After a matching address with a write direction bit, the first byte is a control byte. Bit 7 of that byte selects a stream or a single-byte transfer, and bit 6 selects command or display data. The payload bytes that follow are presented one at a time on `byte_o`, together with a one-cycle `byte_valid_o` strobe and an `is_data_o` flag. A stream runs until the next stop or start. A single transfer carries one payload byte, and the byte after it is parsed as a fresh control byte.

Top module: `disp_i2c_rx`

## Requirements
- R1: A start condition begins address reception from any state, including in the middle of a transfer (repeated start). A stop condition returns the block to idle with SDA released. After reset, `sda_pull_o` and `byte_valid_o` are 0.
- R2: The address byte is bits 7..1 = {0,1,1,1,1,0,`addr_lsb_i`} with bit 0 (direction) = 0, sent MSB first. When it matches, it is acknowledged: `sda_pull_o` is 1 during the ninth SCL high phase.
- R3: If the address differs or bit 0 is 1, that byte is not acknowledged. Until the next start, no later byte is acknowledged or output.
- R4: Every byte after an accepted address is acknowledged. `sda_pull_o` rises only after the eighth SCL falling edge and drops on the falling edge that ends the ninth clock.
- R5: The first byte after an accepted address is a control byte: bit 7 = continuation flag (0 stream, 1 single), bit 6 = payload type (0 command, 1 display data). It is never output.
- R6: With bit 7 = 0 (0x00 command stream, 0x40 data stream), every later byte up to the next stop or start is output, with `is_data_o` equal to bit 6.
- R7: With bit 7 = 1 (0x80 single command, 0xC0 single data), exactly one byte is output with `is_data_o` equal to bit 6, and the next byte is treated as a new control byte.
- R8: Each output byte appears with `byte_valid_o` high for exactly one system clock. `byte_o` carries the bits in the order they were sent, MSB first.
- R9: `sda_pull_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the wire (asynchronous) |
| addr_lsb_i | input | 1 | Strap selecting address bit 0 |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| byte_valid_o | output | 1 | One-cycle strobe for a payload byte |
| byte_o | output | 8 | Payload byte |
| is_data_o | output | 1 | 1 = display data, 0 = command |

## Verification
A wrong link state shows up within one byte time. A missed or spurious acknowledge is seen at the ninth clock of the affected byte, and a bit counter that is off by one corrupts the very next payload byte. A wrong sorter mode shows up on the next payload byte after a control byte: a control byte is output, a byte is dropped, or the command/data flag is wrong. The bench sweeps every address with both direction bits and both strap values. It also runs streams, alternating single transfers, a repeated start that switches mode, and bytes sent after a rejected address or after a stop.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CO_BIT = 7;
  localparam int DC_BIT = 6;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_ADDR,
    LNK_DATA,
    LNK_ACK_WAIT,
    LNK_ACK_DRV,
    LNK_IGNORE
  } lnk_state_e;

  typedef enum logic [1:0] {
    SRT_CTRL,
    SRT_STREAM,
    SRT_SINGLE
  } srt_mode_e;
endpackage

// File: rtl/disp_i2c_sync.sv
module disp_i2c_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;  // idle bus level
      else         ff_q <= {ff_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/disp_i2c_events.sv
module disp_i2c_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/disp_i2c_link.sv
module disp_i2c_link
  import disp_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_lsb_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_pull_o,
  output logic              txn_start_o,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o
);
  lnk_state_e           state_q;
  logic [BIT_CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0]    shift_q;
  logic [BYTE_W-1:0]    shift_nxt;
  logic [6:0]           my_addr;
  logic                 last_bit;

  assign shift_nxt = {shift_q[BYTE_W-2:0], sda_s_i};
  assign my_addr   = {ADDR_BASE[6:1], addr_lsb_i};
  assign last_bit  = (cnt_q == BIT_CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= LNK_IDLE;
      cnt_q       <= '0;
      shift_q     <= '0;
      sda_pull_o  <= 1'b0;
      txn_start_o <= 1'b0;
      byte_stb_o  <= 1'b0;
      byte_o      <= '0;
    end else begin
      txn_start_o <= 1'b0;
      byte_stb_o  <= 1'b0;
      if (start_i) begin
        state_q    <= LNK_ADDR;
        cnt_q      <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        state_q    <= LNK_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state_q)
          LNK_ADDR, LNK_DATA: begin
            if (scl_rise_i) begin
              shift_q <= shift_nxt;
              if (last_bit) begin
                cnt_q <= '0;
                if (state_q == LNK_ADDR) begin
                  if (shift_nxt[7:1] == my_addr && !shift_nxt[0]) begin
                    state_q     <= LNK_ACK_WAIT;
                    txn_start_o <= 1'b1;
                  end else begin
                    state_q <= LNK_IGNORE;
                  end
                end else begin
                  state_q    <= LNK_ACK_WAIT;
                  byte_stb_o <= 1'b1;
                  byte_o     <= shift_nxt;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          LNK_ACK_WAIT: if (scl_fall_i) begin
            sda_pull_o <= 1'b1;
            state_q    <= LNK_ACK_DRV;
          end
          LNK_ACK_DRV: if (scl_fall_i) begin
            sda_pull_o <= 1'b0;
            state_q    <= LNK_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_s_i);  // R9
  AST_START_TO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == LNK_ADDR) && !sda_pull_o);  // R1
  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == LNK_IDLE) && !sda_pull_o);  // R1
  AST_IGNORE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LNK_IGNORE || state_q == LNK_IDLE) |-> !sda_pull_o && !byte_stb_o);  // R3
  AST_PULL_ONLY_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> (state_q == LNK_ACK_DRV));  // R4
endmodule

// File: rtl/disp_i2c_sorter.sv
module disp_i2c_sorter
  import disp_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic              byte_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              is_data_o
);
  srt_mode_e mode_q;
  logic      dc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= SRT_CTRL;
      dc_q      <= 1'b0;
      valid_o   <= 1'b0;
      data_o    <= '0;
      is_data_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (txn_start_i) begin
        mode_q <= SRT_CTRL;
      end else if (byte_stb_i) begin
        if (mode_q == SRT_CTRL) begin
          dc_q   <= byte_i[DC_BIT];
          mode_q <= byte_i[CO_BIT] ? SRT_SINGLE : SRT_STREAM;
        end else begin
          valid_o   <= 1'b1;
          data_o    <= byte_i;
          is_data_o <= dc_q;
          if (mode_q == SRT_SINGLE) mode_q <= SRT_CTRL;
        end
      end
    end
  end

  AST_CTRL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && !txn_start_i && mode_q == SRT_CTRL) |=> !valid_o);  // R5
  AST_SINGLE_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && !txn_start_i && mode_q == SRT_SINGLE) |=> valid_o && (mode_q == SRT_CTRL));  // R7
  AST_STREAM_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && !txn_start_i && mode_q == SRT_STREAM) |=> valid_o && (mode_q == SRT_STREAM));  // R6
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R8
endmodule

// File: rtl/disp_i2c_rx.sv
module disp_i2c_rx
  import disp_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE   = 7'h3C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_lsb_i,
  output logic              sda_pull_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              is_data_o
);
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, bus_start, bus_stop;
  logic              txn_start, byte_stb;
  logic [BYTE_W-1:0] rx_byte;

  disp_i2c_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  disp_i2c_events i_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  disp_i2c_link #(.ADDR_BASE(ADDR_BASE)) i_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_lsb_i (addr_lsb_i),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .sda_pull_o (sda_pull_o),
    .txn_start_o(txn_start),
    .byte_stb_o (byte_stb),
    .byte_o     (rx_byte)
  );

  disp_i2c_sorter i_sorter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .txn_start_i(txn_start),
    .byte_stb_i (byte_stb),
    .byte_i     (rx_byte),
    .valid_o    (byte_valid_o),
    .data_o     (byte_o),
    .is_data_o  (is_data_o)
  );
endmodule

// File: tb/test_disp_i2c_rx.sv
module test_disp_i2c_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;  // system clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       strap = 1'b0;
  logic       sda_pull, byte_valid, is_data;
  logic [7:0] byte_out;
  wire        sda_bus = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];
  bit prev_valid = 0;

  // bench model of the receiver
  bit       m_active = 0;
  int       m_mode = 0;  // 0 ctrl, 1 stream, 2 single
  bit       m_dc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_i2c_rx i_disp_i2c_rx (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .addr_lsb_i  (strap),
    .sda_pull_o  (sda_pull),
    .byte_valid_o(byte_valid),
    .byte_o      (byte_out),
    .is_data_o   (is_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) got_q.push_back({is_data, byte_out});
      if (byte_valid && prev_valid) chk(1'b0, "R8 strobe width", 2, 1);
      prev_valid = byte_valid;
    end
  end

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
    m_active = 0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(2);
    m_active = 0;
  endtask

  // Sends one byte MSB first, returns whether it was acknowledged
  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic p0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq();
      chk(sda_pull == 1'b0, "R4 no pull during data bit", sda_pull, 0);
      wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1;
    p0 = sda_pull;
    wq();
    acked = !sda_bus;
    wq();
    chk(sda_pull == p0, "R9 pull stable while SCL high", sda_pull, p0);
    scl_m = 1'b0; wq();
    chk(sda_pull == 1'b0, "R4 pull released after ninth clock", sda_pull, 0);
  endtask

  task automatic put_addr(input logic [6:0] a, input bit rw);
    bit acked, match;
    match = (a == (7'h3C | {6'b0, strap})) && !rw;
    send_byte({a, rw}, acked);
    if (match) chk(acked == 1'b1, "R2 address ack", acked, 1);
    else       chk(acked == 1'b0, "R3 address nack", acked, 0);
    m_active = match;
    m_mode = 0;
  endtask

  task automatic put_data(input logic [7:0] b);
    bit acked;
    send_byte(b, acked);
    chk(acked == m_active, m_active ? "R4 byte ack" : "R3 byte ignored", acked, m_active);
    if (m_active) begin
      if (m_mode == 0) begin
        m_dc = b[6];
        m_mode = b[7] ? 2 : 1;
      end else begin
        exp_q.push_back({m_dc, b});
        if (m_mode == 2) m_mode = 0;
      end
    end
  endtask

  task automatic compare(input string req);
    wq(2);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      foreach (exp_q[k]) chk(got_q[k] == exp_q[k], req, got_q[k], exp_q[k]);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
    chk(byte_valid == 1'b0, "R1 reset valid", byte_valid, 0);

    // R6 command stream
    bus_start(); put_addr(7'h3C, 0);
    put_data(8'h00); put_data(8'hAE); put_data(8'hD5); put_data(8'h80);
    bus_stop(); compare("R6 command stream");

    // R6 data stream, R8 bit order
    bus_start(); put_addr(7'h3C, 0);
    put_data(8'h40); put_data(8'h01); put_data(8'h80); put_data(8'hA5); put_data(8'hFF);
    bus_stop(); compare("R6 data stream / R8 order");

    // R7 alternating singles, R5 control bytes never output
    bus_start(); put_addr(7'h3C, 0);
    put_data(8'h80); put_data(8'h81);
    put_data(8'hC0); put_data(8'h3C);
    put_data(8'h80); put_data(8'h7F);
    put_data(8'h00); put_data(8'h20); put_data(8'h40);
    bus_stop(); compare("R7 singles then stream / R5");

    // R1 repeated start switches mode
    bus_start(); put_addr(7'h3C, 0);
    put_data(8'h00); put_data(8'hAF);
    bus_start(); put_addr(7'h3C, 0);
    put_data(8'h40); put_data(8'h00); put_data(8'h40);
    bus_stop(); compare("R1 repeated start");

    // R3 rejected address, later bytes ignored
    bus_start(); put_addr(7'h3D, 0);
    put_data(8'h40); put_data(8'h55);
    bus_stop(); compare("R3 no output after nack");

    // R3 read bit rejected
    bus_start(); put_addr(7'h3C, 1);
    put_data(8'hC0); put_data(8'h99);
    bus_stop(); compare("R3 read rejected");

    // R1 bytes after stop without a start are ignored
    bus_start(); put_addr(7'h3C, 0);
    put_data(8'h40); put_data(8'h12);
    bus_stop();
    put_data(8'h34); put_data(8'h56);
    bus_stop(); compare("R1 idle after stop");

    // R2 strap high selects the odd address
    strap = 1'b1;
    bus_start(); put_addr(7'h3D, 0);
    put_data(8'hC0); put_data(8'h6E);
    bus_stop(); compare("R2 strap high");

    // Sweep: every address, strap low, write
    strap = 1'b0;
    for (int a = 0; a < 128; a++) begin
      bus_start(); put_addr(7'(a), 0);
      put_data(8'hC0); put_data(8'(a) ^ 8'h5A);
      bus_stop(); compare("R2 R3 R7 address sweep");
    end
    // Sweep: addresses only, read bit with strap low, both bits with strap high
    for (int s = 0; s < 2; s++) begin
      strap = s[0];
      for (int a = 0; a < 128; a++) begin
        for (int rw = s ? 0 : 1; rw < 2; rw++) begin
          bus_start(); put_addr(7'(a), rw[0]); bus_stop();
        end
      end
    end
    compare("R3 address-only sweep");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule